// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block supervises a host microcontroller through two active-low outputs: a reset line and a watchdog-fault line. Software keeps the watchdog alive by writing its service register over a small register bus. That bus takes the place of a serial front end. Each watchdog period has two halves. The first half is closed, and a service write landing there is a fault. The second half is open, and a service write there is accepted and starts a new period. If the period runs out with no accepted service, that is also a fault.

The response to a fault depends on the mode bit. In normal mode, a fault pulls the reset line low for a fixed stretch. In safe mode, a fault leaves the reset line alone. In both modes the fault line goes low and stays low until the next accepted service. Reset is also driven low in three other cases: at power-on (`rst_n`), on a wake-up event, and while the digital supply-good input reports the supply below its threshold. After any reset pulse the block is back in normal mode, with the shortest period and a fresh closed window.

Top module: `wdw_supervisor`

## Requirements
- R1: While `rst_n` is low, both `rst_out_n` and `wdf_n` are low. After `rst_n` rises, both stay low for exactly RST_CYCLES clock edges and then both go high together.
- R2: When `wake_evt` is high at a clock edge, both outputs go low after that edge. They stay low for RST_CYCLES edges counted from that edge, and then both go high together.
- R3: When `supply_ok` is low at an edge, `rst_out_n` is low after that edge and stays low while `supply_ok` stays low. It goes high RST_CYCLES edges after `supply_ok` returns high. This cause does not pull `wdf_n` low.
- R4: The service register sits at bus address 1, and its bits [1:0] select the period as PERIOD_BASE << sel cycles. The window count starts at 0. The window is closed while the count is below half the period and open from half the period onward. Every reset pulse sets sel back to 0 and restarts the count at 0.
- R5: A write to address 1 in the open window is a valid service, including the last cycle of the period. It restarts the count, loads sel, leaves both outputs high, and sets `wdf_n` high if it was low.
- R6: A write to address 1 while the window is closed is a watchdog fault.
- R7: If no valid service arrives, a watchdog fault occurs at the edge where the count reaches the end of the period. That is the P-th edge after the count was last restarted.
- R8: In normal mode, a watchdog fault drives `rst_out_n` and `wdf_n` low after the faulting edge. `rst_out_n` is released RST_CYCLES edges later. `wdf_n` stays low until a valid service.
- R9: Bit 0 of address 0 is the safe-mode bit, where 1 means safe. In safe mode a watchdog fault drives `wdf_n` low, leaves `rst_out_n` high, and restarts the count.
- R10: Every reset pulse returns the block to normal mode.
- R11: These writes are ignored: any write while `rst_out_n` is low, and any write to address 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok | input | 1 | High when the supply is above its reset threshold |
| wake_evt | input | 1 | Wake-up event, sampled at each edge |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address (0 mode, 1 service) |
| bus_wdata | input | DATA_W | Write data |
| rst_out_n | output | 1 | Active-low reset to the host |
| wdf_n | output | 1 | Active-low watchdog-fault flag |

## Verification
The assertions assume that `supply_ok`, `wake_evt` and the bus signals are synchronous to `clk` and change only between edges. They also assume that each bus write is a single-cycle strobe. The bench drives every input on the falling edge and makes each write a one-cycle pulse. It returns the block to power-on reset before each scenario, so the window position it tracks is never stale. Boundary writes are placed on the last closed cycle, the first open cycle and the final open cycle, because those edges separate a valid service from a fault.

// File: rtl/wdw_pkg.sv
// Package: shared register addresses and the decoded write type for the
// window watchdog supervisor. Assumes a two-bit register address space.
package wdw_pkg;

    localparam int ADDR_W = 2;
    localparam int SEL_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SVC  = 2'd1;

    // One decoded bus write, already qualified by the reset state.
    typedef struct packed {
        logic mode_wr;
        logic svc_wr;
    } wr_dec_t;

endpackage

// File: rtl/wdw_regs.sv
// Module: register bank. Holds the safe-mode bit and the period select and
// produces the service request strobe. Assumes one-cycle write strobes.
// Every write is dropped while a reset pulse is active (hold high), and a
// reset pulse sets both registers back to their defaults.
module wdw_regs
    import wdw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              svc_ok,
    output logic              safe,
    output logic [SEL_W-1:0]  sel,
    output logic              svc_req
);

    wr_dec_t    dec;
    logic       safe_q;
    logic [SEL_W-1:0] sel_q;
    logic       unused_hi;

    // Decode the write and suppress it while reset is being driven.
    always_comb begin
        dec.mode_wr = bus_wr && !hold && (bus_addr == ADDR_MODE);
        dec.svc_wr  = bus_wr && !hold && (bus_addr == ADDR_SVC);
    end

    // Upper data bits carry no function.
    assign unused_hi = ^bus_wdata[DATA_W-1:SEL_W];

    // Update the mode bit and period select; defaults after any reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            safe_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            if (dec.mode_wr) begin
                safe_q <= bus_wdata[0];
            end
            if (svc_ok) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
        end
    end

    assign safe    = safe_q;
    assign sel     = sel_q;
    assign svc_req = dec.svc_wr;

endmodule

// File: rtl/wdw_window.sv
// Module: window counter. Counts the watchdog period and tells apart a
// service in the open half from one in the closed half. It also flags a
// timeout at the end of the period. Assumes PERIOD_BASE is even and at
// least 2, and that CNT_W can hold PERIOD_BASE*8-1.
module wdw_window
    import wdw_pkg::*;
#(
    parameter int PERIOD_BASE = 32,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    input  logic             svc_req,
    output logic             svc_ok,
    output logic             wd_fault
);

    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] last_tbl [NSEL];
    logic [CNT_W-1:0] half_tbl [NSEL];
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;
    logic             is_open;

    // One period entry per select value.
    for (genvar g = 0; g < NSEL; g++) begin : g_per
        assign last_tbl[g] = CNT_W'((PERIOD_BASE << g) - 1);
        assign half_tbl[g] = CNT_W'((PERIOD_BASE << g) / 2);
    end

    // Window position relative to the selected period.
    always_comb begin
        at_end  = (cnt_q == last_tbl[sel]);
        is_open = (cnt_q >= half_tbl[sel]);
    end

    // Advance the count; restart on any service, fault or reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
        end else if (svc_req || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign svc_ok   = !hold && svc_req && is_open;
    assign wd_fault = !hold && ((svc_req && !is_open) || (at_end && !svc_req));

endmodule

// File: rtl/wdw_rst_ctl.sv
// Module: reset and fault-flag control. Stretches every reset cause to
// RST_CYCLES edges and tracks the watchdog fault flag. Power-on and wake
// pulses hold both outputs low. A supply pulse touches only the reset line.
// Assumes its inputs are synchronous to clk.
module wdw_rst_ctl #(
    parameter int RST_CYCLES = 16,
    parameter int RST_W      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wake_evt,
    input  logic wd_fault,
    input  logic safe,
    input  logic svc_ok,
    output logic rst_act,
    output logic rst_out_n,
    output logic wdf_n
);

    localparam logic [RST_W-1:0] CNT_LAST = RST_W'(RST_CYCLES - 1);

    logic             act_q;
    logic             start_q;
    logic             fault_q;
    logic [RST_W-1:0] cnt_q;

    // Start, stretch and end reset pulses; keep the fault flag up to date.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b1;
            start_q <= 1'b1;
            fault_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (!supply_ok) begin
                act_q <= 1'b1;
                cnt_q <= '0;
            end else if (wake_evt) begin
                act_q   <= 1'b1;
                start_q <= 1'b1;
                cnt_q   <= '0;
            end else if (wd_fault && !safe) begin
                act_q <= 1'b1;
                cnt_q <= '0;
            end else if (act_q) begin
                if (cnt_q == CNT_LAST) begin
                    act_q   <= 1'b0;
                    start_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            if (wake_evt) begin
                fault_q <= 1'b0;
            end else if (wd_fault) begin
                fault_q <= 1'b1;
            end else if (svc_ok) begin
                fault_q <= 1'b0;
            end
        end
    end

    assign rst_act   = act_q;
    assign rst_out_n = !act_q;
    assign wdf_n     = !(fault_q || start_q);

endmodule

// File: rtl/wdw_supervisor.sv
// Module: top of the window watchdog supervisor. Connects the register
// bank, the window counter and the reset control. Assumes all inputs are
// synchronous to clk and that bus writes are one-cycle strobes.
module wdw_supervisor
    import wdw_pkg::*;
#(
    parameter int PERIOD_BASE = 32,
    parameter int RST_CYCLES  = 16,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              wake_evt,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rst_out_n,
    output logic              wdf_n
);

    localparam int CNT_W = $clog2(PERIOD_BASE * 8);
    localparam int RST_W = $clog2(RST_CYCLES + 1);

    logic             rst_act;
    logic             safe_q;
    logic [SEL_W-1:0] sel_q;
    logic             svc_req;
    logic             svc_ok;
    logic             wd_fault;

    wdw_regs #(
        .DATA_W(DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (rst_act),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .svc_ok   (svc_ok),
        .safe     (safe_q),
        .sel      (sel_q),
        .svc_req  (svc_req)
    );

    wdw_window #(
        .PERIOD_BASE(PERIOD_BASE),
        .CNT_W      (CNT_W)
    ) win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (rst_act),
        .sel     (sel_q),
        .svc_req (svc_req),
        .svc_ok  (svc_ok),
        .wd_fault(wd_fault)
    );

    wdw_rst_ctl #(
        .RST_CYCLES(RST_CYCLES),
        .RST_W     (RST_W)
    ) rctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .wake_evt (wake_evt),
        .wd_fault (wd_fault),
        .safe     (safe_q),
        .svc_ok   (svc_ok),
        .rst_act  (rst_act),
        .rst_out_n(rst_out_n),
        .wdf_n    (wdf_n)
    );

endmodule

// File: rtl/wdw_supervisor_chk.sv
// Module: assertion checker for the window watchdog supervisor, bound to
// the top. Assumes inputs change only between clock edges.
module wdw_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic wake_evt,
    input logic rst_out_n,
    input logic wdf_n,
    input logic safe_q,
    input logic wd_fault,
    input logic svc_ok
);

    AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !rst_out_n); // R3

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (!rst_out_n && !wdf_n)); // R2

    AST_WD_CAUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_out_n) && $past(supply_ok) && !$past(wake_evt)) |-> !wdf_n); // R8

    AST_FLAG_RISE_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdf_n) |-> rst_out_n); // R5

    AST_NORMAL_FAULT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!safe_q && wd_fault && rst_out_n) |=> !rst_out_n); // R8

    AST_SAFE_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_q && wd_fault && supply_ok && !wake_evt && rst_out_n) |=> (rst_out_n && !wdf_n)); // R9

    AST_SERVICE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && !wake_evt) |=> wdf_n); // R5

    AST_NO_SERVICE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> (!svc_ok && !wd_fault)); // R11

endmodule

bind wdw_supervisor wdw_supervisor_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .wake_evt (wake_evt),
    .rst_out_n(rst_out_n),
    .wdf_n    (wdf_n),
    .safe_q   (safe_q),
    .wd_fault (wd_fault),
    .svc_ok   (svc_ok)
);

// File: tb/wdw_supervisor_tb.sv
// Directed bench for the window watchdog supervisor: one task per scenario.
module wdw_supervisor_tb_top;

    localparam int P   = 32;
    localparam int RST = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b1;
    logic       wake_evt = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       rst_out_n;
    logic       wdf_n;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    wdw_supervisor #(.PERIOD_BASE(P), .RST_CYCLES(RST), .DATA_W(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .wake_evt (wake_evt),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .rst_out_n(rst_out_n),
        .wdf_n    (wdf_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic apply_por();
        rst_n = 1'b0; supply_ok = 1'b1; wake_evt = 1'b0; bus_wr = 1'b0;
        ticks(3);
        rst_n = 1'b1;
    endtask

    task automatic wait_release();
        for (int g = 0; g < 2000 && rst_out_n !== 1'b1; g++) @(negedge clk);
    endtask

    task automatic t_power_on();
        rst_n = 1'b0;
        ticks(3);
        chk("R1", "rst_out_n in por", rst_out_n, 1'b0);
        chk("R1", "wdf_n in por", wdf_n, 1'b0);
        rst_n = 1'b1;
        ticks(RST - 1);
        chk("R1", "rst_out_n last pulse cycle", rst_out_n, 1'b0);
        chk("R1", "wdf_n last pulse cycle", wdf_n, 1'b0);
        ticks(1);
        chk("R1", "rst_out_n released", rst_out_n, 1'b1);
        chk("R1", "wdf_n released", wdf_n, 1'b1);
    endtask

    task automatic t_wake();
        apply_por(); wait_release();
        wake_evt = 1'b1; ticks(1); wake_evt = 1'b0;
        chk("R2", "rst_out_n after wake", rst_out_n, 1'b0);
        chk("R2", "wdf_n after wake", wdf_n, 1'b0);
        ticks(RST - 1);
        chk("R2", "rst_out_n end of wake pulse", rst_out_n, 1'b0);
        ticks(1);
        chk("R2", "rst_out_n wake released", rst_out_n, 1'b1);
        chk("R2", "wdf_n wake released", wdf_n, 1'b1);
    endtask

    task automatic t_supply();
        apply_por(); wait_release();
        supply_ok = 1'b0; ticks(1);
        chk("R3", "rst_out_n supply low", rst_out_n, 1'b0);
        chk("R3", "wdf_n supply low", wdf_n, 1'b1);
        ticks(40);
        chk("R3", "rst_out_n held", rst_out_n, 1'b0);
        supply_ok = 1'b1;
        ticks(RST - 1);
        chk("R3", "rst_out_n before release", rst_out_n, 1'b0);
        ticks(1);
        chk("R3", "rst_out_n after return", rst_out_n, 1'b1);
        chk("R3", "wdf_n after return", wdf_n, 1'b1);
    endtask

    task automatic t_open_service();
        apply_por(); wait_release();
        ticks(P / 2);
        bus_write(2'd1, 8'd0);
        chk("R5", "first open cycle service rst", rst_out_n, 1'b1);
        chk("R5", "first open cycle service wdf", wdf_n, 1'b1);
        for (int k = 0; k < 3; k++) begin
            ticks(P - 1);
            bus_write(2'd1, 8'd0);
        end
        chk("R5", "last open cycle services rst", rst_out_n, 1'b1);
        chk("R5", "last open cycle services wdf", wdf_n, 1'b1);
        ticks(P - 1);
        chk("R7", "no timeout before P", rst_out_n, 1'b1);
        ticks(1);
        chk("R7", "timeout at P after service", rst_out_n, 1'b0);
    endtask

    task automatic t_closed_service();
        apply_por(); wait_release();
        ticks(P / 2 - 1);
        bus_write(2'd1, 8'd0);
        chk("R6", "last closed cycle write rst", rst_out_n, 1'b0);
        chk("R6", "last closed cycle write wdf", wdf_n, 1'b0);
    endtask

    task automatic t_timeout_normal();
        apply_por(); wait_release();
        ticks(P - 1);
        chk("R7", "high one before end", rst_out_n, 1'b1);
        ticks(1);
        chk("R8", "rst_out_n after timeout", rst_out_n, 1'b0);
        chk("R8", "wdf_n after timeout", wdf_n, 1'b0);
        ticks(RST - 1);
        chk("R8", "rst still low", rst_out_n, 1'b0);
        ticks(1);
        chk("R8", "rst released after stretch", rst_out_n, 1'b1);
        chk("R8", "wdf held after release", wdf_n, 1'b0);
        ticks(P / 2);
        bus_write(2'd1, 8'd0);
        chk("R5", "service clears wdf", wdf_n, 1'b1);
    endtask

    task automatic t_safe();
        apply_por(); wait_release();
        bus_write(2'd0, 8'd1);
        ticks(P - 2);
        chk("R9", "safe before timeout wdf", wdf_n, 1'b1);
        ticks(1);
        chk("R9", "safe timeout rst stays high", rst_out_n, 1'b1);
        chk("R9", "safe timeout wdf low", wdf_n, 1'b0);
        ticks(P / 2);
        bus_write(2'd1, 8'd0);
        chk("R9", "count restarted, service valid", wdf_n, 1'b1);
        bus_write(2'd1, 8'd0);
        chk("R9", "safe closed write wdf low", wdf_n, 1'b0);
        ticks(3);
        chk("R9", "safe closed write rst high", rst_out_n, 1'b1);
    endtask

    task automatic t_mode_reverts();
        apply_por(); wait_release();
        bus_write(2'd0, 8'd1);
        supply_ok = 1'b0; ticks(5); supply_ok = 1'b1;
        wait_release();
        ticks(P);
        chk("R10", "normal mode after pulse", rst_out_n, 1'b0);
    endtask

    task automatic t_period_sel();
        apply_por(); wait_release();
        ticks(P / 2);
        bus_write(2'd1, 8'd2);
        ticks(4 * P - 1);
        chk("R4", "sel 2 no timeout at 4P-1", rst_out_n, 1'b1);
        ticks(1);
        chk("R4", "sel 2 timeout at 4P", rst_out_n, 1'b0);
        wait_release();
        ticks(P - 1);
        chk("R4", "sel back to 0 before end", rst_out_n, 1'b1);
        ticks(1);
        chk("R4", "sel back to 0 timeout", rst_out_n, 1'b0);
    endtask

    task automatic t_ignored();
        apply_por();
        ticks(1);
        bus_write(2'd0, 8'd1);
        bus_write(2'd1, 8'd3);
        wait_release();
        bus_write(2'd3, 8'd0);
        bus_write(2'd2, 8'd0);
        chk("R11", "unused address closed write rst", rst_out_n, 1'b1);
        chk("R11", "unused address closed write wdf", wdf_n, 1'b1);
        ticks(P - 3);
        chk("R11", "period unchanged before end", rst_out_n, 1'b1);
        ticks(1);
        chk("R11", "writes in reset ignored", rst_out_n, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_power_on();
        t_wake();
        t_supply();
        t_open_service();
        t_closed_service();
        t_timeout_normal();
        t_safe();
        t_mode_reverts();
        t_period_sel();
        t_ignored();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule